// File: doc/BRIEF.md
# Clock-Crossing Timer Control Register

This block is the bus-side control register of a timer peripheral whose counting core runs on a separate, slower, unrelated clock. Software writes an operating mode, an enable and a software-reset request into one 8-bit control register. The mode goes straight to the core. Enable changes and reset requests are carried into the core clock domain by a toggle handshake. A busy flag in a status register stays set until the core side acknowledges the request.

A written enable value reads back in the next bus cycle, before the core has seen it. A write that sets the reset bit is a request and nothing else: every other field of that write is dropped. When the core acknowledges the reset, the control register returns to zero and the peripheral is left disabled. A separate debug register is not touched by this reset. While a request is still in flight, further enable and reset writes are ignored. Mode writes are still taken during that time.

Top module: `ctrl_sync_reg`

## Requirements
- R1: After power-on reset, the control (address 0), status (address 1) and debug (address 2) registers all read 0, and `core_en_o`, `core_mode_o` and `core_swrst_o` are 0.
- R2: The control register holds reset-request at bit 0, enable at bit 1 and mode at bits 3:2. Bits 7:4 of control and bits 7:1 of status always read 0. Address 3 reads 0.
- R3: A control write with bit 0 = 0 while not busy shows its enable value on a control read in the next bus cycle. If that value differs from the current enable, the busy flag (status bit 0) reads 1 in the same cycle.
- R4: The busy flag clears by itself once the core domain has applied the new enable. From then on `core_en_o` equals the written enable value.
- R5: The mode field drives `core_mode_o` unsynchronized from the next bus cycle. Mode codes: 0 is the 32-bit counter, 1 the 16-bit counter, 2 clock/calendar, 3 reserved. Mode writes are accepted even while busy.
- R6: A control write with bit 0 = 1 while not busy discards the enable and mode bits of that write. It makes control bit 0 and the busy flag read 1 until the reset completes.
- R7: When a reset completes, control bit 0 and the busy flag clear in the same cycle. The whole control register then reads 0, `core_en_o` is 0, and `core_swrst_o` has pulsed exactly once.
- R8: The debug register keeps its value through a software reset.
- R9: While busy, the enable and reset bits of control writes are ignored.
- R10: A control write that leaves the enable value unchanged and has bit 0 = 0 does not set the busy flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 debug |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| core_clk_i | input | 1 | Core domain clock |
| core_en_o | output | 1 | Synchronized enable into the core domain |
| core_mode_o | output | 2 | Operating mode, unsynchronized |
| core_swrst_o | output | 1 | One core-cycle reset pulse into the core domain |

## Verification
The hardest situation to reach is a write that lands while a handshake is still in flight. The slow core clock only leaves a window of a few bus cycles for it. The stimulus issues a second control write in the bus cycle right after an enable change. That write carries an opposite enable, a reset bit and a new mode, so the bench can see that only the mode is taken. Random rounds then mix reset and enable writes, each with random mode and reserved bits. The bus and core clocks are unrelated, so the acknowledge lands at varying phases.

// File: rtl/ctrl_sync_pkg.sv
package ctrl_sync_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DBG  = 2'd2;

  // bit positions inside the control register
  localparam int unsigned BIT_RST  = 0;
  localparam int unsigned BIT_EN   = 1;
  localparam int unsigned MODE_LSB = 2;

  typedef enum logic [1:0] {
    MODE_CNT32 = 2'd0,
    MODE_CNT16 = 2'd1,
    MODE_CAL   = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;
endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ctrl_sync_core.sv
module ctrl_sync_core #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_tgl_i,
  input  logic req_en_i,   // quasi-static while request is open
  input  logic req_rst_i,  // quasi-static while request is open
  output logic ack_tgl_o,
  output logic en_o,
  output logic swrst_o
);
  logic req_s;
  logic ack_q, en_q, swrst_q;
  logic req_new;

  tgl_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_i),
    .q_o   (req_s)
  );

  assign req_new = req_s ^ ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      en_q    <= 1'b0;
      swrst_q <= 1'b0;
    end else begin
      ack_q   <= req_s;
      swrst_q <= req_new && req_rst_i;
      if (req_new) en_q <= req_rst_i ? 1'b0 : req_en_i;
    end
  end

  assign ack_tgl_o = ack_q;
  assign en_o      = en_q;
  assign swrst_o   = swrst_q;

  AST_RST_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |-> !en_q); // R7
  AST_ACK_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q == req_s) |=> $stable(en_q) || $past(req_s) != $past(ack_q)); // R4
endmodule

// File: rtl/ctrl_sync_reg.sv
module ctrl_sync_reg
  import ctrl_sync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              core_clk_i,
  output logic              core_en_o,
  output logic [1:0]        core_mode_o,
  output logic              core_swrst_o
);
  mode_e             mode_q;
  logic              en_q, rst_pend_q, busy_q;
  logic              req_tgl_q, req_en_q, req_rst_q;
  logic [DATA_W-1:0] dbg_q;
  logic              ack_tgl, ack_s, ack_prev_q, ack_edge;
  logic              ctrl_wr, start_rst, start_en;

  assign ctrl_wr   = we_i && (addr_i == ADDR_CTRL);
  assign start_rst = ctrl_wr && !busy_q && wdata_i[BIT_RST];
  assign start_en  = ctrl_wr && !busy_q && !wdata_i[BIT_RST] && (wdata_i[BIT_EN] != en_q);
  assign ack_edge  = ack_s ^ ack_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_CNT32;
      en_q       <= 1'b0;
      rst_pend_q <= 1'b0;
      busy_q     <= 1'b0;
      req_tgl_q  <= 1'b0;
      req_en_q   <= 1'b0;
      req_rst_q  <= 1'b0;
      ack_prev_q <= 1'b0;
    end else begin
      ack_prev_q <= ack_s;
      if (ctrl_wr && !start_rst) mode_q <= mode_e'(wdata_i[MODE_LSB +: 2]);
      if (start_rst) begin
        rst_pend_q <= 1'b1;
        busy_q     <= 1'b1;
        req_tgl_q  <= ~req_tgl_q;
        req_rst_q  <= 1'b1;
      end else if (start_en) begin
        en_q      <= wdata_i[BIT_EN];
        busy_q    <= 1'b1;
        req_tgl_q <= ~req_tgl_q;
        req_en_q  <= wdata_i[BIT_EN];
        req_rst_q <= 1'b0;
      end
      // completion wins over a same-cycle mode write
      if (ack_edge) begin
        busy_q <= 1'b0;
        if (rst_pend_q) begin
          rst_pend_q <= 1'b0;
          en_q       <= 1'b0;
          mode_q     <= MODE_CNT32;
        end
      end
    end
  end

  // debug register: outside the software reset
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                            dbg_q <= '0;
    else if (we_i && addr_i == ADDR_DBG)    dbg_q <= wdata_i;

  tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl),
    .q_o   (ack_s)
  );

  ctrl_sync_core #(.STAGES(SYNC_STAGES)) u_core (
    .clk_i    (core_clk_i),
    .rst_ni   (rst_ni),
    .req_tgl_i(req_tgl_q),
    .req_en_i (req_en_q),
    .req_rst_i(req_rst_q),
    .ack_tgl_o(ack_tgl),
    .en_o     (core_en_o),
    .swrst_o  (core_swrst_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[BIT_RST]          = rst_pend_q;
        rdata_o[BIT_EN]           = en_q;
        rdata_o[MODE_LSB +: 2]    = mode_q;
      end
      ADDR_STAT: rdata_o[0] = busy_q;
      ADDR_DBG:  rdata_o    = dbg_q;
      default:   rdata_o    = '0;
    endcase
  end

  assign core_mode_o = mode_q;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_DBG) |-> rdata_o[DATA_W-1:4] == '0); // R2
  AST_PEND_IMPLIES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pend_q |-> busy_q); // R6
  AST_RST_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !busy_q && wdata_i[BIT_RST]) |=> $stable(en_q) && $stable(mode_q)); // R6
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_edge) |=> $stable(req_tgl_q) && $stable(en_q) && busy_q); // R9
  AST_RST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rst_pend_q)) |-> !busy_q && !en_q && mode_q == MODE_CNT32); // R7
  AST_DBG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(we_i && addr_i == ADDR_DBG)) |=> $stable(dbg_q)); // R8
endmodule

// File: tb/ctrl_sync_reg_tb_top.sv
module ctrl_sync_reg_tb_top;
  logic       clk = 1'b0, core_clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic       core_en, core_swrst;
  logic [1:0] core_mode;

  int n_chk = 0, n_fail = 0, n_pulse = 0;
  bit done = 1'b0;

  // model state
  bit       m_en;
  bit [1:0] m_mode;
  bit [7:0] m_dbg;

  always #5 clk = ~clk;
  always #18.5 core_clk = ~core_clk;

  always @(negedge core_clk) if (core_swrst) n_pulse++;

  ctrl_sync_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .core_clk_i(core_clk), .core_en_o(core_en),
    .core_mode_o(core_mode), .core_swrst_o(core_swrst));

  function automatic logic [7:0] exp_ctrl(bit rst, bit en, bit [1:0] mode);
    return {4'b0, mode, en, rst};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // read at current negedge region, combinational path
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  // poll busy until clear; returns cycles waited
  task automatic wait_idle(input string req, output int cyc);
    logic [7:0] s;
    cyc = 0;
    rd(2'd1, s);
    while (s[0] && cyc < 200) begin
      @(negedge clk); cyc++; rd(2'd1, s);
    end
    chk(!s[0], req, s, 0);
  endtask

  task automatic do_enable(input bit en, input bit [1:0] mode, input bit [3:0] rsv);
    logic [7:0] d;
    int cyc;
    bit chg = (en != m_en);
    wr(2'd0, {rsv, mode, en, 1'b0});
    m_en = en; m_mode = mode;
    rd(2'd0, d);
    chk(d == exp_ctrl(0, m_en, m_mode), "R3 readback", d, exp_ctrl(0, m_en, m_mode));
    chk(core_mode == m_mode, "R5 mode passthrough", core_mode, m_mode);
    @(negedge clk); rd(2'd1, d);
    if (chg) chk(d == 8'h01, "R3 busy set", d, 1);
    else     chk(d == 8'h00, "R10 no busy", d, 0);
    wait_idle("R4 busy clears", cyc);
    repeat (8) @(negedge core_clk);
    @(negedge clk);
    chk(core_en == m_en, "R4 core enable", core_en, m_en);
  endtask

  task automatic do_swrst(input bit [7:0] d_in);
    logic [7:0] d;
    int cyc, p0;
    p0 = n_pulse;
    wr(2'd0, d_in | 8'h01);
    rd(2'd0, d);
    chk(d == exp_ctrl(1, m_en, m_mode), "R6 fields discarded", d, exp_ctrl(1, m_en, m_mode));
    rd(2'd1, d);
    chk(d == 8'h01, "R6 busy during reset", d, 1);
    wait_idle("R7 reset completes", cyc);
    rd(2'd0, d);
    chk(d == 8'h00, "R7 ctrl cleared", d, 0);
    m_en = 0; m_mode = 0;
    repeat (6) @(negedge core_clk);
    @(negedge clk);
    chk(core_en == 1'b0, "R7 core disabled", core_en, 0);
    chk(n_pulse == p0 + 1, "R7 one reset pulse", n_pulse - p0, 1);
    rd(2'd2, d);
    chk(d == m_dbg, "R8 debug kept", d, m_dbg);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int cyc;
    void'($urandom(32'h5eed_1234));
    m_en = 0; m_mode = 0; m_dbg = 0;
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk(d == 0, "R1 ctrl reset", d, 0);
    rd(2'd1, d); chk(d == 0, "R1 status reset", d, 0);
    rd(2'd2, d); chk(d == 0, "R1 debug reset", d, 0);
    chk({core_en, core_mode, core_swrst} == 0, "R1 core outputs", {core_en, core_mode, core_swrst}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    wr(2'd2, 8'hA5); m_dbg = 8'hA5;
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk(d == 0, "R2 unmapped address", d, 0);

    // reserved bits written high
    do_enable(1'b1, 2'd2, 4'hF);
    rd(2'd0, d); chk(d[7:4] == 0, "R2 reserved zero", d, {4'b0, d[3:0]});
    do_enable(1'b1, 2'd1, 4'h0);   // same enable: R10

    // write during busy: only mode taken (R9, R5)
    wr(2'd0, 8'h02);               // enable -> 0? no: already 1, force change
    do_enable(1'b0, 2'd0, 4'h0);
    wr(2'd0, {4'h0, 2'd3, 1'b1, 1'b0}); m_en = 1; m_mode = 3;
    wr(2'd0, {4'h0, 2'd2, 1'b0, 1'b1}); m_mode = 2;
    rd(2'd0, d);
    chk(d == exp_ctrl(0, 1, 2), "R9 ignored while busy", d, exp_ctrl(0, 1, 2));
    chk(core_mode == 2'd2, "R5 mode while busy", core_mode, 2);
    wait_idle("R9 busy clears", cyc);
    repeat (8) @(negedge core_clk); @(negedge clk);
    chk(core_en == 1'b1, "R9 core keeps first enable", core_en, 1);

    // reset with every other field set
    do_swrst(8'hFE);

    for (int i = 0; i < 40; i++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) do_swrst(8'($urandom()));
      else if (op == 1) begin
        m_dbg = 8'($urandom()); wr(2'd2, m_dbg);
        rd(2'd2, d); chk(d == m_dbg, "R8 debug write", d, m_dbg);
      end else do_enable(1'($urandom()), 2'($urandom()), 4'($urandom()));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule